// File: doc/BRIEF.md
# Set-Associative Tag Array with Lock-Aware LRU Replacement

This block keeps the tag, the coherence state and an age stamp for every line of an N-way set-associative cache. It answers hit lookups, installs lines on a fill, and reports the line that a fill pushes out. Data storage and coherence messaging belong to neighbouring blocks.

Replacement is least-recently-used. A single stamp counter is written into a line each time that line hits or is filled, and the counter then advances. A line whose address still has an outstanding miss entry is locked. The block presents the line address held in every way of the fill set to the miss tracker. The tracker returns one lock bit per way, and a locked way is never chosen as a victim. When every way of the set is locked and no way already holds the tag, the fill cannot proceed. The block raises a stall in the same cycle, and the requester holds the fill and offers it again.

Lines are interleaved in the physical array. Way `w` of set `s` sits at index `s + (w << SET_BITS)`. An evicted line's address is rebuilt from its stored tag and the set number.

Top module: `tagarr_lru`

## Requirements
- R1: After reset every line is Invalid (state code 0), so no lookup hits, and lk_hit, fill_done, ev_valid and inv_err are all 0.
- R2: A lookup uses set = addr[BLOCK_BITS +: SET_BITS] and tag = addr[ADDR_W-1 : SET_BITS+BLOCK_BITS]. The low BLOCK_BITS offset bits are ignored. lk_hit and lk_way are registered and appear one cycle after lk_valid.
- R3: A hit needs a matching tag and a state other than Invalid. A line with a matching tag but Invalid state misses.
- R4: On a fill, a way whose stored tag already equals the fill tag is chosen first. That way takes the new state and reports no eviction.
- R5: Failing a tag match, the lowest-numbered way that is Invalid and unlocked is chosen, and no eviction is reported.
- R6: Failing that, the unlocked way with the smallest stamp is chosen. Each hit and each fill stamps its line with the counter value, and the counter then increments.
- R7: A way whose lq_locked bit is set is never chosen as a victim, whether it is Invalid or valid. The lq_addr slice for way w carries {stored tag, fill set}.
- R8: If no way qualifies, fill_stall is high in the same cycle. The array is then left unchanged and fill_done stays 0.
- R9: When a valid line is displaced, ev_valid is 1 with fill_done, and ev_line = {stored tag, set}. ev_state is the old state (0 Invalid, 1 Shared, 2 Exclusive, 3 Modified). ev_wb is 1 only if that state is Modified and WRITE_BACK is 1.
- R10: An invalidate that hits an unlocked line sets it to Invalid. One that hits with inv_locked high pulses inv_err for one cycle and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_hit | output | 1 | Registered hit result |
| lk_way | output | WAY_W | Registered hit way |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | ADDR_W | Fill byte address |
| fill_state | input | 2 | State written into the filled line |
| fill_stall | output | 1 | No eligible way this cycle; hold and retry |
| fill_done | output | 1 | Registered: fill was installed |
| fill_way | output | WAY_W | Registered: way that was written |
| ev_valid | output | 1 | Registered: a valid line was displaced |
| ev_line | output | ADDR_W-BLOCK_BITS | Line address of the displaced line |
| ev_state | output | 2 | State of the displaced line |
| ev_wb | output | 1 | Displaced line needs a write to the next level |
| lq_addr | output | WAYS*(ADDR_W-BLOCK_BITS) | Line address held in each way of the fill set |
| lq_locked | input | WAYS | Miss tracker: way's line has an outstanding miss |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | ADDR_W | Invalidate byte address |
| inv_locked | input | 1 | Miss tracker: inv_addr has an outstanding miss |
| inv_err | output | 1 | Registered: invalidate refused because the line is locked |

## Verification
The bench drives one set into the state where its oldest line is locked, and checks that the next-oldest line is evicted. A design that ignores locks would throw out a line that a miss is still waiting on. It also invalidates a way and then locks it, so the fill must bypass the free way and fall back to age order. A design that checks only the state would fill over a locked line. A fill with every way locked must stall and leave the array intact, and a tag-matching fill must upgrade its line in place. A design that got the upgrade wrong would evict a live line or duplicate the tag. Finally, a Modified line is aged until it becomes the victim. Its rebuilt address and its write-back flag expose any error in rebuilding the address from tag and set.

// File: rtl/tagarr_pkg.sv
package tagarr_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        VK_NONE  = 2'd0,
        VK_MATCH = 2'd1,
        VK_FREE  = 2'd2,
        VK_LRU   = 2'd3
    } victim_kind_e;
endpackage

// File: rtl/tagarr_set_cmp.sv
module tagarr_set_cmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 12
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0][1:0]       way_st,
    input  logic [TAG_W-1:0]           ref_tag,
    output logic [WAYS-1:0]            tag_eq,
    output logic [WAYS-1:0]            live_hit
);
    import tagarr_pkg::*;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_eq[w]   = (way_tag[w] == ref_tag);
        assign live_hit[w] = tag_eq[w] && (way_st[w] != LS_INV);
    end
endmodule

// File: rtl/tagarr_victim_pick.sv
module tagarr_victim_pick #(
    parameter int WAYS    = 4,
    parameter int STAMP_W = 16,
    parameter int WAY_W   = 2
) (
    input  logic [WAYS-1:0]              tag_eq,
    input  logic [WAYS-1:0]              free,
    input  logic [WAYS-1:0]              locked,
    input  logic [WAYS-1:0][STAMP_W-1:0] age,
    output logic                         found,
    output logic [WAY_W-1:0]             way,
    output tagarr_pkg::victim_kind_e     kind
);
    import tagarr_pkg::*;

    logic               m_any, f_any, l_any;
    logic [WAY_W-1:0]   m_way, f_way, l_way;
    logic [STAMP_W-1:0] l_age;

    always_comb begin
        m_any = 1'b0; m_way = '0;
        f_any = 1'b0; f_way = '0;
        l_any = 1'b0; l_way = '0; l_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (tag_eq[w] && !m_any) begin
                m_any = 1'b1;
                m_way = WAY_W'(w);
            end
            if (free[w] && !locked[w] && !f_any) begin
                f_any = 1'b1;
                f_way = WAY_W'(w);
            end
            if (!locked[w] && (!l_any || age[w] < l_age)) begin
                l_any = 1'b1;
                l_way = WAY_W'(w);
                l_age = age[w];
            end
        end
        if (m_any) begin
            found = 1'b1; way = m_way; kind = VK_MATCH;
        end else if (f_any) begin
            found = 1'b1; way = f_way; kind = VK_FREE;
        end else if (l_any) begin
            found = 1'b1; way = l_way; kind = VK_LRU;
        end else begin
            found = 1'b0; way = '0; kind = VK_NONE;
        end
    end
endmodule

// File: rtl/tagarr_lru.sv
module tagarr_lru #(
    parameter int ADDR_W     = 16,
    parameter int BLOCK_BITS = 2,
    parameter int SET_BITS   = 2,
    parameter int WAYS       = 4,
    parameter int STAMP_W    = 16,
    parameter bit WRITE_BACK = 1'b1,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W    = ADDR_W - BLOCK_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [ADDR_W-1:0]        lk_addr,
    output logic                     lk_hit,
    output logic [WAY_W-1:0]         lk_way,
    input  logic                     fill_valid,
    input  logic [ADDR_W-1:0]        fill_addr,
    input  logic [1:0]               fill_state,
    output logic                     fill_stall,
    output logic                     fill_done,
    output logic [WAY_W-1:0]         fill_way,
    output logic                     ev_valid,
    output logic [LINE_W-1:0]        ev_line,
    output logic [1:0]               ev_state,
    output logic                     ev_wb,
    output logic [WAYS*LINE_W-1:0]   lq_addr,
    input  logic [WAYS-1:0]          lq_locked,
    input  logic                     inv_valid,
    input  logic [ADDR_W-1:0]        inv_addr,
    input  logic                     inv_locked,
    output logic                     inv_err
);
    import tagarr_pkg::*;

    localparam int SETS  = 1 << SET_BITS;
    localparam int LINES = SETS * WAYS;
    localparam int TAG_W = ADDR_W - SET_BITS - BLOCK_BITS;
    localparam int IDX_W = WAY_W + SET_BITS;

    typedef struct packed {
        logic [LINES-1:0][TAG_W-1:0]   tag;
        logic [LINES-1:0][1:0]         st;
        logic [LINES-1:0][STAMP_W-1:0] age;
        logic [STAMP_W-1:0]            stamp;
        logic                          hit;
        logic [WAY_W-1:0]              hit_way;
        logic                          fdone;
        logic [WAY_W-1:0]              fway;
        logic                          evv;
        logic [LINE_W-1:0]             evl;
        logic [1:0]                    evs;
        logic                          evwb;
        logic                          ierr;
    } regs_t;

    regs_t r_d, r_q;

    // Address fields of the three ports
    logic [TAG_W-1:0]    lk_tag, fl_tag, iv_tag;
    logic [SET_BITS-1:0] lk_set, fl_set, iv_set;
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign fl_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign iv_tag = inv_addr[ADDR_W-1 -: TAG_W];
    assign lk_set = lk_addr[BLOCK_BITS +: SET_BITS];
    assign fl_set = fill_addr[BLOCK_BITS +: SET_BITS];
    assign iv_set = inv_addr[BLOCK_BITS +: SET_BITS];

    logic unused_offsets;
    assign unused_offsets = ^{lk_addr[BLOCK_BITS-1:0], fill_addr[BLOCK_BITS-1:0],
                              inv_addr[BLOCK_BITS-1:0]};

    // Per-way views of each addressed set (interleaved placement)
    logic [WAYS-1:0][TAG_W-1:0]   lk_tag_w, fl_tag_w, iv_tag_w;
    logic [WAYS-1:0][1:0]         lk_st_w, fl_st_w, iv_st_w;
    logic [WAYS-1:0][STAMP_W-1:0] fl_age_w;
    logic [WAYS-1:0]              fl_free;

    for (genvar w = 0; w < WAYS; w++) begin : g_view
        assign lk_tag_w[w] = r_q.tag[{WAY_W'(w), lk_set}];
        assign lk_st_w[w]  = r_q.st[{WAY_W'(w), lk_set}];
        assign fl_tag_w[w] = r_q.tag[{WAY_W'(w), fl_set}];
        assign fl_st_w[w]  = r_q.st[{WAY_W'(w), fl_set}];
        assign fl_age_w[w] = r_q.age[{WAY_W'(w), fl_set}];
        assign iv_tag_w[w] = r_q.tag[{WAY_W'(w), iv_set}];
        assign iv_st_w[w]  = r_q.st[{WAY_W'(w), iv_set}];
        assign fl_free[w]  = (fl_st_w[w] == LS_INV);
        assign lq_addr[w*LINE_W +: LINE_W] = {fl_tag_w[w], fl_set};
    end

    logic [WAYS-1:0] lk_live, fl_eq, iv_live;
    logic [WAYS-1:0] unused_lk_eq, unused_fl_live, unused_iv_eq;

    tagarr_set_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_lk (
        .way_tag(lk_tag_w), .way_st(lk_st_w), .ref_tag(lk_tag),
        .tag_eq(unused_lk_eq), .live_hit(lk_live));
    tagarr_set_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_fl (
        .way_tag(fl_tag_w), .way_st(fl_st_w), .ref_tag(fl_tag),
        .tag_eq(fl_eq), .live_hit(unused_fl_live));
    tagarr_set_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_iv (
        .way_tag(iv_tag_w), .way_st(iv_st_w), .ref_tag(iv_tag),
        .tag_eq(unused_iv_eq), .live_hit(iv_live));

    logic         v_found;
    logic [WAY_W-1:0] v_way;
    victim_kind_e v_kind;

    tagarr_victim_pick #(.WAYS(WAYS), .STAMP_W(STAMP_W), .WAY_W(WAY_W)) u_pick (
        .tag_eq(fl_eq), .free(fl_free), .locked(lq_locked), .age(fl_age_w),
        .found(v_found), .way(v_way), .kind(v_kind));

    assign fill_stall = fill_valid && !v_found;

    logic [WAY_W-1:0]   lk_enc, iv_enc;
    logic [IDX_W-1:0]   idx;
    logic [STAMP_W-1:0] stamp;

    always_comb begin
        lk_enc = '0;
        iv_enc = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_live[w]) lk_enc = WAY_W'(w);
            if (iv_live[w]) iv_enc = WAY_W'(w);
        end

        r_d        = r_q;
        r_d.hit    = 1'b0;
        r_d.fdone  = 1'b0;
        r_d.evv    = 1'b0;
        r_d.evl    = '0;
        r_d.evs    = LS_INV;
        r_d.evwb   = 1'b0;
        r_d.ierr   = 1'b0;
        stamp      = r_q.stamp;
        idx        = '0;

        if (inv_valid && |iv_live) begin
            if (inv_locked) r_d.ierr = 1'b1;
            else            r_d.st[{iv_enc, iv_set}] = LS_INV;
        end

        if (lk_valid && |lk_live) begin
            r_d.hit     = 1'b1;
            r_d.hit_way = lk_enc;
            r_d.age[{lk_enc, lk_set}] = stamp;
            stamp       = stamp + 1'b1;
        end

        if (fill_valid && v_found) begin
            idx = {v_way, fl_set};
            if (v_kind == VK_LRU && fl_st_w[v_way] != LS_INV) begin
                r_d.evv  = 1'b1;
                r_d.evl  = {fl_tag_w[v_way], fl_set};
                r_d.evs  = fl_st_w[v_way];
                r_d.evwb = WRITE_BACK && (fl_st_w[v_way] == LS_MOD);
            end
            r_d.tag[idx] = fl_tag;
            r_d.st[idx]  = fill_state;
            r_d.age[idx] = stamp;
            stamp        = stamp + 1'b1;
            r_d.fdone    = 1'b1;
            r_d.fway     = v_way;
        end

        r_d.stamp = stamp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lk_hit    = r_q.hit;
    assign lk_way    = r_q.hit_way;
    assign fill_done = r_q.fdone;
    assign fill_way  = r_q.fway;
    assign ev_valid  = r_q.evv;
    assign ev_line   = r_q.evl;
    assign ev_state  = r_q.evs;
    assign ev_wb     = r_q.evwb;
    assign inv_err   = r_q.ierr;
endmodule

// File: rtl/tagarr_lru_chk.sv
module tagarr_lru_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic       lk_hit,
    input logic       fill_valid,
    input logic       fill_stall,
    input logic       fill_done,
    input logic       ev_valid,
    input logic [1:0] ev_state,
    input logic       ev_wb,
    input logic       inv_valid,
    input logic       inv_locked,
    input logic       inv_err
);
    a_r2_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_valid));

    a_r8_stall_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_stall) |=> !fill_done);

    a_r8_done_needs_clear_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> $past(fill_valid && !fill_stall));

    a_r9_evict_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (fill_done && ev_state != 2'd0));

    a_r9_wb_only_modified: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wb |-> (ev_valid && ev_state == 2'd3));

    a_r10_err_needs_locked_inv: assert property (@(posedge clk) disable iff (!rst_n)
        inv_err |-> $past(inv_valid && inv_locked));
endmodule

bind tagarr_lru tagarr_lru_chk chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .fill_valid(fill_valid), .fill_stall(fill_stall), .fill_done(fill_done),
    .ev_valid(ev_valid), .ev_state(ev_state), .ev_wb(ev_wb),
    .inv_valid(inv_valid), .inv_locked(inv_locked), .inv_err(inv_err)
);

// File: tb/tagarr_lru_tb_top.sv
`timescale 1ns/1ps
module tagarr_lru_tb_top;
    localparam int LW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             lk_valid = 0, fill_valid = 0, inv_valid = 0, inv_locked = 0;
    logic [15:0]      lk_addr = '0, fill_addr = '0, inv_addr = '0;
    logic [1:0]       fill_state = 2'd1;
    logic             lk_hit, fill_stall, fill_done, ev_valid, ev_wb, inv_err;
    logic [1:0]       lk_way, fill_way, ev_state;
    logic [LW-1:0]    ev_line;
    logic [4*LW-1:0]  lq_addr;
    logic [3:0]       lq_locked;

    logic [LW-1:0] lock_tab [4];
    logic          lock_on  [4];

    always_comb begin
        for (int w = 0; w < 4; w++) begin
            lq_locked[w] = 1'b0;
            for (int k = 0; k < 4; k++)
                if (lock_on[k] && lock_tab[k] == lq_addr[w*LW +: LW]) lq_locked[w] = 1'b1;
        end
    end

    tagarr_lru dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_way(lk_way), .fill_valid(fill_valid),
        .fill_addr(fill_addr), .fill_state(fill_state), .fill_stall(fill_stall),
        .fill_done(fill_done), .fill_way(fill_way), .ev_valid(ev_valid),
        .ev_line(ev_line), .ev_state(ev_state), .ev_wb(ev_wb), .lq_addr(lq_addr),
        .lq_locked(lq_locked), .inv_valid(inv_valid), .inv_addr(inv_addr),
        .inv_locked(inv_locked), .inv_err(inv_err));

    int checks = 0, fails = 0;

    localparam logic [11:0] TA = 12'h0A1, TB = 12'h0B2, TC = 12'h0C3, TD = 12'h0D4,
                            TE = 12'h0E5, TF = 12'h0F6, TG = 12'h107, TH = 12'h118,
                            TJ = 12'h129;

    function automatic logic [15:0] mk(input logic [11:0] t, input logic [1:0] s,
                                       input logic [1:0] off);
        return {t, s, off};
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [15:0] a, input logic eh, input logic [1:0] ew,
                          input string rq);
        @(negedge clk); lk_valid = 1; lk_addr = a;
        @(negedge clk); lk_valid = 0;
        check(rq, "lk_hit", lk_hit, eh);
        if (eh) check(rq, "lk_way", lk_way, ew);
    endtask

    task automatic fill(input logic [11:0] t, input logic [1:0] st, input logic [1:0] ew,
                        input logic eev, input logic [11:0] et, input logic [1:0] es,
                        input logic ewb, input string rq);
        @(negedge clk); fill_valid = 1; fill_addr = mk(t, 2'd1, 2'd0); fill_state = st;
        #1 check(rq, "fill_stall", fill_stall, 0);
        @(negedge clk); fill_valid = 0;
        check(rq, "fill_done", fill_done, 1);
        check(rq, "fill_way", fill_way, ew);
        check(rq, "ev_valid", ev_valid, eev);
        if (eev) begin
            check(rq, "ev_line", ev_line, {et, 2'd1});
            check(rq, "ev_state", ev_state, es);
            check(rq, "ev_wb", ev_wb, ewb);
        end
    endtask

    task automatic invalidate(input logic [11:0] t, input logic lk, input logic eerr,
                              input string rq);
        @(negedge clk); inv_valid = 1; inv_addr = mk(t, 2'd1, 2'd0); inv_locked = lk;
        @(negedge clk); inv_valid = 0; inv_locked = 0;
        check(rq, "inv_err", inv_err, eerr);
    endtask

    task automatic set_lock(input int k, input logic [11:0] t, input logic on);
        lock_tab[k] = {t, 2'd1};
        lock_on[k]  = on;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", "lk_hit", lk_hit, 0);
        check("R1", "fill_done", fill_done, 0);
        check("R1", "ev_valid", ev_valid, 0);
        check("R1", "inv_err", inv_err, 0);
        lookup(mk(TA, 2'd1, 2'd0), 0, 0, "R1");
    endtask

    task automatic t_fill_free_and_lookup;
        fill(TA, 2'd1, 2'd0, 0, 0, 0, 0, "R5");
        fill(TB, 2'd1, 2'd1, 0, 0, 0, 0, "R5");
        fill(TC, 2'd1, 2'd2, 0, 0, 0, 0, "R5");
        fill(TD, 2'd1, 2'd3, 0, 0, 0, 0, "R5");
        lookup(mk(TA, 2'd1, 2'd0), 1, 2'd0, "R2");
        lookup(mk(TB, 2'd1, 2'd0), 1, 2'd1, "R2");
        lookup(mk(TC, 2'd1, 2'd0), 1, 2'd2, "R2");
        lookup(mk(TD, 2'd1, 2'd0), 1, 2'd3, "R2");
        lookup(mk(TA, 2'd1, 2'd3), 1, 2'd0, "R2");   // offset ignored
        lookup(mk(TA, 2'd2, 2'd0), 0, 0, "R2");      // other set
        lookup(mk(TE, 2'd1, 2'd0), 0, 0, "R2");
    endtask

    task automatic t_lru_and_lock;
        fill(TE, 2'd1, 2'd1, 1, TB, 2'd1, 0, "R6");  // B oldest
        set_lock(0, TC, 1);                           // C oldest but locked
        fill(TF, 2'd1, 2'd3, 1, TD, 2'd1, 0, "R7");
    endtask

    task automatic t_all_locked;
        set_lock(1, TA, 1); set_lock(2, TE, 1); set_lock(3, TF, 1);
        @(negedge clk); fill_valid = 1; fill_addr = mk(TG, 2'd1, 2'd0); fill_state = 2'd1;
        #1;
        check("R8", "fill_stall", fill_stall, 1);
        check("R7", "lq_addr way0", lq_addr[0 +: LW], {TA, 2'd1});
        check("R7", "lq_addr way2", lq_addr[2*LW +: LW], {TC, 2'd1});
        @(negedge clk); fill_valid = 0;
        check("R8", "fill_done", fill_done, 0);
        lookup(mk(TG, 2'd1, 2'd0), 0, 0, "R8");
        for (int k = 0; k < 4; k++) lock_on[k] = 0;
    endtask

    task automatic t_upgrade_and_writeback;
        fill(TC, 2'd3, 2'd2, 0, 0, 0, 0, "R4");
        lookup(mk(TC, 2'd1, 2'd0), 1, 2'd2, "R4");
        lookup(mk(TA, 2'd1, 2'd0), 1, 2'd0, "R6");
        lookup(mk(TE, 2'd1, 2'd0), 1, 2'd1, "R6");
        lookup(mk(TF, 2'd1, 2'd0), 1, 2'd3, "R6");
        fill(TG, 2'd1, 2'd2, 1, TC, 2'd3, 1, "R9");
    endtask

    task automatic t_invalidate;
        invalidate(TE, 0, 0, "R10");
        lookup(mk(TE, 2'd1, 2'd0), 0, 0, "R3");
        fill(TH, 2'd1, 2'd1, 0, 0, 0, 0, "R5");
        invalidate(TA, 1, 1, "R10");
        lookup(mk(TA, 2'd1, 2'd0), 1, 2'd0, "R10");
        invalidate(TA, 0, 0, "R10");
        set_lock(0, TA, 1);                            // free way0 is locked
        fill(TJ, 2'd1, 2'd3, 1, TF, 2'd1, 0, "R7");
        lock_on[0] = 0;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin lock_tab[k] = '0; lock_on[k] = 0; end
        t_reset;
        t_fill_free_and_lookup;
        t_lru_and_lock;
        t_all_locked;
        t_upgrade_and_writeback;
        t_invalidate;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule